// File: doc/BRIEF.md
# Test Pattern Source

This block supplies data to a serial-link transmit path. It either forwards application samples from an upstream valid/ready stream or generates one of three test patterns. The patterns are an alternating checkerboard, an incrementing ramp and a 7-bit pseudo-random binary sequence. A 4-bit mode code selects the source. The mode code and the data path share one clock.

The mode code is registered once. A new code therefore takes effect on the output one cycle after it is presented. Any change of code restarts the pattern generators from their initial states on that same edge. A generated pattern advances only on a word the downstream side accepts, so back-pressure never drops or skips a pattern word. Codes that select no source leave the output idle.

Top module: `test_pattern_source`

## Requirements
- R1: While `rst_n` is low, the registered mode is pass-through (code 4'b0000) and every generator is held at its initial state.
- R2: With registered code 4'b0000, `out_data` equals `in_data`, `out_valid` equals `in_valid`, and `in_ready` equals `out_ready`, all within the same cycle.
- R3: Code 4'b1000 produces a checkerboard. The first word has every odd bit set (0xAA… pattern), and each accepted word is followed by its bitwise complement.
- R4: Code 4'b1001 produces a ramp. It starts at zero, adds one per accepted word and wraps modulo 2^DATA_W.
- R5: Code 4'b1010 produces PRBS-7 (x^7+x^6+1) from seed 7'h7F. One step per bit: the new bit is state[6]^state[5] and is shifted into state[0]. Each word holds the next DATA_W new bits, the first at the MSB.
- R6: In any of the three pattern modes, `out_valid` is high and `in_ready` is low.
- R7: In a pattern mode, a cycle with `out_ready` low leaves the next word equal to the current one.
- R8: Any other code gives `out_data` all zeros, `out_valid` low and `in_ready` low.
- R9: A code presented before a clock edge governs the output from that edge onward. If the code differs from the registered one, the newly selected pattern starts from its initial state after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 4 | Source selection code |
| in_data | input | DATA_W | Upstream sample |
| in_valid | input | 1 | Upstream sample valid |
| in_ready | output | 1 | Block accepts an upstream sample |
| out_data | output | DATA_W | Word towards the link |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |

## Verification
Several properties are checked on every cycle:
- the pass-through equalities;
- the valid/ready levels in pattern and idle modes;
- the hold of a stalled word;
- the checkerboard complement and the ramp step between accepted words;
- the restart values of the checkerboard and the ramp.

The PRBS bit order and seed can only be shown by the bench, which compares complete word sequences against an independent model. The bench also covers the ramp wrap after 2^DATA_W words, the behaviour during reset and the one-cycle lag of a mode change behind the code input.

// File: rtl/tps_pkg.sv
// Package: mode codes and pattern indices shared by the test pattern source.
// Assumes: the 4-bit code encoding is fixed and not configurable.
package tps_pkg;

    typedef enum logic [3:0] {
        MODE_NORMAL  = 4'b0000,
        MODE_CHECKER = 4'b1000,
        MODE_RAMP    = 4'b1001,
        MODE_PRBS    = 4'b1010
    } tps_mode_e;

    localparam int NUM_PAT     = 3;
    localparam int PAT_CHECKER = 0;
    localparam int PAT_RAMP    = 1;
    localparam int PAT_PRBS    = 2;

    // Maps a generator index to the mode code that selects it.
    function automatic logic [3:0] pat_code(input int idx);
        case (idx)
            PAT_CHECKER: pat_code = MODE_CHECKER;
            PAT_RAMP:    pat_code = MODE_RAMP;
            default:     pat_code = MODE_PRBS;
        endcase
    endfunction

endpackage

// File: rtl/tps_mode_ctrl.sv
// Module: registers the mode code, flags a code change and decodes the selection.
// Assumes: mode_i is synchronous to clk; reset selects pass-through.
module tps_mode_ctrl
    import tps_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         mode_i,
    output logic               restart,
    output logic               is_pass,
    output logic [NUM_PAT-1:0] pat_sel
);

    logic [3:0] mode_q;

    // Mode register: holds the code that governs the current cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_NORMAL;
        else        mode_q <= mode_i;
    end

    // Change detect: generators reinitialise on the edge that loads a new code.
    always_comb restart = (mode_i != mode_q);

    // Pass-through decode.
    always_comb is_pass = (mode_q == MODE_NORMAL);

    for (genvar k = 0; k < NUM_PAT; k++) begin : g_sel
        // One-hot generator select.
        always_comb pat_sel[k] = (mode_q == pat_code(k));
    end

endmodule

// File: rtl/tps_pattern_gen.sv
// Module: one pattern generator; KIND picks checkerboard, ramp or PRBS-7.
// Assumes: restart has priority over advance; the word is valid every cycle.
module tps_pattern_gen
    import tps_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int KIND   = PAT_CHECKER
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    output logic [DATA_W-1:0] word
);

    // Odd bits set: the 0xAA.. word at any width.
    function automatic logic [DATA_W-1:0] odd_bits();
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) r[i] = (i % 2) == 1;
        return r;
    endfunction

    localparam logic [DATA_W-1:0] CHK_FIRST = odd_bits();
    localparam logic [6:0]        PRBS_SEED = 7'h7F;

    if (KIND == PAT_CHECKER) begin : g_chk
        logic phase_q;

        // Phase toggle per accepted word.
        always_ff @(posedge clk) begin
            if (!rst_n || restart) phase_q <= 1'b0;
            else if (advance)      phase_q <= ~phase_q;
        end

        // Word select from the phase.
        always_comb word = phase_q ? ~CHK_FIRST : CHK_FIRST;

    end else if (KIND == PAT_RAMP) begin : g_ramp
        logic [DATA_W-1:0] count_q;

        // Ramp counter, wraps naturally at 2^DATA_W.
        always_ff @(posedge clk) begin
            if (!rst_n || restart) count_q <= '0;
            else if (advance)      count_q <= count_q + 1'b1;
        end

        // Output the counter value.
        always_comb word = count_q;

    end else begin : g_prbs
        logic [6:0] lfsr_q;
        logic [6:0] lfsr_d;

        // Unrolled DATA_W steps of x^7+x^6+1, first new bit to the MSB.
        always_comb begin
            logic [6:0] s;
            logic       nb;
            s  = lfsr_q;
            nb = 1'b0;
            for (int i = DATA_W - 1; i >= 0; i--) begin
                nb      = s[6] ^ s[5];
                word[i] = nb;
                s       = {s[5:0], nb};
            end
            lfsr_d = s;
        end

        // LFSR state register, one word of steps per accepted word.
        always_ff @(posedge clk) begin
            if (!rst_n || restart) lfsr_q <= PRBS_SEED;
            else if (advance)      lfsr_q <= lfsr_d;
        end
    end

endmodule

// File: rtl/test_pattern_source.sv
// Module: selects pass-through streaming or a generated test pattern by mode code.
// Assumes: single clock domain; a mode change shows one cycle after mode_i.
module test_pattern_source
    import tps_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        mode_i,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);

    logic               restart;
    logic               is_pass;
    logic [NUM_PAT-1:0] pat_sel;
    logic [DATA_W-1:0]  pat_word [NUM_PAT];

    tps_mode_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .restart (restart),
        .is_pass (is_pass),
        .pat_sel (pat_sel)
    );

    for (genvar k = 0; k < NUM_PAT; k++) begin : g_gen
        tps_pattern_gen #(
            .DATA_W (DATA_W),
            .KIND   (k)
        ) u_gen (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart),
            .advance (pat_sel[k] & out_ready),
            .word    (pat_word[k])
        );
    end

    // Output mux: pass-through, selected pattern, or idle for reserved codes.
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        if (is_pass) begin
            out_data  = in_data;
            out_valid = in_valid;
            in_ready  = out_ready;
        end else begin
            for (int k = 0; k < NUM_PAT; k++) begin
                if (pat_sel[k]) begin
                    out_data  = pat_word[k];
                    out_valid = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tps_checks.sv
// Module: cycle-level properties of the test pattern source, attached by bind.
// Assumes: sampled on the same clock and reset as the design.
module tps_checks
    import tps_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        mode_i,
    input logic [DATA_W-1:0] in_data,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_ready
);

    logic [3:0] seen_mode;
    logic       gen_mode;
    logic       keep_mode;
    logic [DATA_W-1:0] chk_first;

    // Code observed at the last edge, as the requirements define it.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_mode <= MODE_NORMAL;
        else        seen_mode <= mode_i;
    end

    always_comb begin
        gen_mode  = (seen_mode == MODE_CHECKER) || (seen_mode == MODE_RAMP) ||
                    (seen_mode == MODE_PRBS);
        keep_mode = (mode_i == seen_mode);
        for (int i = 0; i < DATA_W; i++) chk_first[i] = (i % 2) == 1;
    end

    p_pass_through_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_mode == MODE_NORMAL) |->
            (out_data == in_data && out_valid == in_valid && in_ready == out_ready));

    p_gen_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gen_mode |-> (out_valid && !in_ready));

    p_reserved_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_mode && seen_mode != MODE_NORMAL) |->
            (!out_valid && !in_ready && out_data == '0));

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_mode && keep_mode && !out_ready) |=> $stable(out_data));

    p_checker_alt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_mode == MODE_CHECKER && keep_mode && out_ready) |=>
            (out_data == ~$past(out_data)));

    p_ramp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_mode == MODE_RAMP && keep_mode && out_ready) |=>
            (out_data == $past(out_data) + 1'b1));

    p_ramp_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_RAMP && !keep_mode) |=> (out_data == '0));

    p_checker_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_CHECKER && !keep_mode) |=> (out_data == chk_first));

endmodule

bind test_pattern_source tps_checks #(.DATA_W(DATA_W)) u_tps_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready)
);

// File: tb/test_test_pattern_source.sv
// Bench: scoreboard of expected words; the monitor compares accepted output words.
module test_test_pattern_source;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   mode_i = 4'b1000;
    logic [W-1:0] in_data = '0;
    logic         in_valid = 1'b1;
    logic         in_ready;
    logic [W-1:0] out_data;
    logic         out_valid;
    logic         out_ready = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;
    logic [W-1:0] exp_q[$];
    string        tag_q[$];

    always #2 clk = ~clk;

    test_pattern_source #(.DATA_W(W)) i_test_pattern_source (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Monitor: pops and compares each accepted word.
    always @(negedge clk) begin
        if (mon_en && out_valid && out_ready) begin
            if (exp_q.size() == 0) check("unexpected word", {24'h0, out_data}, 32'hFFFF_FFFF);
            else check(tag_q.pop_front(), {24'h0, out_data}, {24'h0, exp_q.pop_front()});
        end
    end

    // Driver: selects a pattern mode, queues n expected words, drains with stalls.
    task automatic run_pattern(input logic [3:0] code, input int n, input string req);
        logic [6:0] s;
        logic [W-1:0] w;
        logic [W-1:0] held;
        bit stalled;
        int cyc;
        @(posedge clk); #1;
        mode_i = code; out_ready = 1'b0; in_valid = 1'b0;
        @(posedge clk); #1;
        s = 7'h7F;
        for (int j = 0; j < n; j++) begin
            if (code == 4'b1000) w = (j % 2 == 0) ? 8'hAA : 8'h55;
            else if (code == 4'b1001) w = W'(j);
            else begin
                for (int i = W - 1; i >= 0; i--) begin
                    w[i] = s[6] ^ s[5];
                    s = {s[5:0], w[i]};
                end
            end
            exp_q.push_back(w);
            tag_q.push_back(req);
        end
        mon_en = 1'b1;
        cyc = 0;
        stalled = 1'b0;
        held = '0;
        while (exp_q.size() > 0) begin
            out_ready = (cyc % 3) != 2;
            @(negedge clk);
            if (cyc < 6) begin
                check("R6 out_valid", {31'h0, out_valid}, 32'h1);
                check("R6 in_ready", {31'h0, in_ready}, 32'h0);
            end
            if (stalled) check("R7 stall hold", {24'h0, out_data}, {24'h0, held});
            stalled = !out_ready;
            held = out_data;
            @(posedge clk); #1;
            cyc++;
        end
        mon_en = 1'b0;
        out_ready = 1'b0;
    endtask

    // Driver: pass-through words with gaps on both sides.
    task automatic run_pass(input int n);
        @(posedge clk); #1;
        mode_i = 4'b0000;
        @(posedge clk); #1;
        mon_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            in_data = W'(i * 37 + 5);
            in_valid = (i % 4) != 3;
            out_ready = (i % 5) != 4;
            if (in_valid && out_ready) begin
                exp_q.push_back(in_data);
                tag_q.push_back("R2 pass data");
            end
            @(negedge clk);
            check("R2 in_ready", {31'h0, in_ready}, {31'h0, out_ready});
            check("R2 out_valid", {31'h0, out_valid}, {31'h0, in_valid});
            @(posedge clk); #1;
        end
        mon_en = 1'b0;
    endtask

    task automatic check_reserved(input logic [3:0] code);
        @(posedge clk); #1;
        mode_i = code; in_valid = 1'b1; out_ready = 1'b1; in_data = 8'hC3;
        @(posedge clk); #1;
        @(negedge clk);
        check("R8 out_valid", {31'h0, out_valid}, 32'h0);
        check("R8 out_data", {24'h0, out_data}, 32'h0);
        check("R8 in_ready", {31'h0, in_ready}, 32'h0);
    endtask

    initial begin
        // R1: during reset the block passes through, even with a pattern code present.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset out_valid", {31'h0, out_valid}, 32'h1);
        check("R1 reset in_ready", {31'h0, in_ready}, 32'h1);
        check("R1 reset out_data", {24'h0, out_data}, 32'h0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        out_ready = 1'b0;
        // R3 straight after reset: checkerboard starts at 0xAA.
        @(posedge clk); #1;
        @(negedge clk);
        check("R1 R3 first word", {24'h0, out_data}, 32'hAA);

        run_pattern(4'b1000, 9, "R3 checker");
        run_pattern(4'b1001, 20, "R4 ramp");
        run_pattern(4'b1000, 4, "R9 checker restart");
        run_pattern(4'b1010, 40, "R5 prbs");
        run_pattern(4'b1001, 260, "R4 ramp wrap");
        run_pattern(4'b1010, 5, "R9 prbs restart");
        run_pass(30);
        check_reserved(4'b1111);
        check_reserved(4'b0001);
        check_reserved(4'b1011);

        // R9: the code takes effect only after the next edge.
        run_pass(2);
        @(posedge clk); #1;
        in_valid = 1'b1; out_ready = 1'b1; in_data = 8'h3C;
        mode_i = 4'b1111;
        @(negedge clk);
        check("R9 lag valid", {31'h0, out_valid}, 32'h1);
        check("R9 lag data", {24'h0, out_data}, 32'h3C);
        @(posedge clk); #1;
        @(negedge clk);
        check("R9 after edge valid", {31'h0, out_valid}, 32'h0);

        report();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

endmodule